// File: doc/BRIEF.md
# Byte Arithmetic Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it takes two byte operands, A and B, and a 4-bit operation code. When the execute strobe is high and the code names one of the ten supported operations, it registers a byte result and an 8-bit condition byte. The supported operations are add, subtract, multiply, divide, shift left, shift right, complement, AND, XOR and OR. Both outputs then hold until the next executed operation, so a downstream jump unit can test the condition bits at any later time.

The operation is always A op B. Subtract gives A minus B, divide gives A over B, and the shifts move A by the number of places held in B. The arithmetic cores are combinational, and this includes a fully unrolled restoring divider. A single register stage holds the result and the flags, so each operation takes one cycle.

Top module: `alu8_core`

## Requirements
- R1: Opcode values are 0100 add, 0101 subtract, 0110 multiply, 0111 divide, 1000 shift left, 1001 shift right, 1010 complement, 1011 AND, 1100 XOR and 1101 OR. An operation sampled with `exec_i` high at a rising edge appears on `result_o` and `flags_o` right after that edge, and back-to-back operations each produce their own result.
- R2: Add returns (A+B) mod 256. The carry flag (bit 2) is the carry out of bit 7. The overflow flag (bit 3) is set on signed two's-complement overflow.
- R3: Subtract returns (A-B) mod 256. The carry flag is set when A < B unsigned (borrow). The overflow flag is set on signed two's-complement overflow.
- R4: Multiply returns the low byte of the unsigned product. The carry flag is set when the high byte of the product is non-zero. The overflow flag is cleared.
- R5: Divide returns the unsigned truncated quotient with carry and overflow cleared. When B is 0, the result is 0xFF, overflow is set and carry is cleared.
- R6: Shift left and shift right move A by B places and fill with zeros. If B is 0, the result is A and carry is 0. If B is 8 or more, the result is 0x00. Carry holds the last bit shifted out, which is bit 8-B of A (left) or bit B-1 of A (right) for B from 1 to 8, and 0 for B of 9 or more. Overflow is cleared.
- R7: Complement returns ~A and does not depend on B. AND, XOR and OR return the bitwise result of A and B. All four clear carry and overflow.
- R8: After every executed operation, the zero flag (bit 0) is 1 exactly when the result is 0x00, the negative flag (bit 1) equals result bit 7, and flag bits 7:4 are 0.
- R9: When `exec_i` is low, or the opcode is outside 0100 to 1101, `result_o` and `flags_o` keep their values.
- R10: While `rst_n` is low, `result_o` and `flags_o` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe; the operation is sampled at the rising edge |
| opcode_i | input | 4 | Operation code |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B (second operand or shift amount) |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flags: bit 0 zero, 1 negative, 2 carry, 3 overflow |

## Verification
The assertions check on every cycle that the outputs hold when no valid operation executes, and that the zero and negative bits match the registered result after each operation. They also check that divide by zero yields 0xFF with overflow, that logic and multiply operations leave overflow clear, and that shifts of 8 or more places yield zero. The bench scenarios are what show the exact arithmetic values. These include the carry and overflow corners of add and subtract, the high-byte carry of multiply, truncating division, the last-bit-out carry of both shifts, and complement with different B values. The bench also covers invalid opcodes and back-to-back execution.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int OPW = 4;
    localparam int FW  = 8;

    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_C = 2;
    localparam int FLG_V = 3;

    localparam logic [OPW-1:0] OP_ADD = 4'b0100;
    localparam logic [OPW-1:0] OP_SUB = 4'b0101;
    localparam logic [OPW-1:0] OP_MUL = 4'b0110;
    localparam logic [OPW-1:0] OP_DIV = 4'b0111;
    localparam logic [OPW-1:0] OP_SHL = 4'b1000;
    localparam logic [OPW-1:0] OP_SHR = 4'b1001;
    localparam logic [OPW-1:0] OP_NOT = 4'b1010;
    localparam logic [OPW-1:0] OP_AND = 4'b1011;
    localparam logic [OPW-1:0] OP_XOR = 4'b1100;
    localparam logic [OPW-1:0] OP_OR  = 4'b1101;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          v;
    } unit_out_t;

    typedef struct packed {
        logic [DW-1:0] result;
        logic [FW-1:0] flags;
    } alu_state_t;

    function automatic logic is_alu_op(input logic [OPW-1:0] op);
        return (op >= OP_ADD) && (op <= OP_OR);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum_w;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_w = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        res_o = sum_w[W-1:0];
        // borrow is the inverse of the carry out when subtracting
        c_o   = sub_i ? ~sum_w[W] : sum_w[W];
        v_o   = (a_i[W-1] == b_eff[W-1]) && (sum_w[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         div_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod_w;
    logic [W-1:0]  quot_w;
    logic [W:0]    rem_w;

    always_comb begin
        prod_w = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    end

    // unrolled restoring division, one compare/subtract per quotient bit
    always_comb begin
        rem_w  = '0;
        quot_w = '0;
        for (int i = W - 1; i >= 0; i--) begin
            rem_w = {rem_w[W-1:0], a_i[i]};
            if (rem_w >= {1'b0, b_i}) begin
                rem_w     = rem_w - {1'b0, b_i};
                quot_w[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (div_i) begin
            res_o = (b_i == '0) ? {W{1'b1}} : quot_w;
            c_o   = 1'b0;
            v_o   = (b_i == '0);
        end else begin
            res_o = prod_w[W-1:0];
            c_o   = |prod_w[PW-1:W];
            v_o   = 1'b0;
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] amt_i,
    input  logic         right_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam int SW = $clog2(W) + 1;   // enough bits to hold amounts 0..W
    localparam int XW = 2 * W;

    logic           big;
    logic [SW-1:0]  amt_s;
    logic [XW-1:0]  ext_l;
    logic [XW-1:0]  ext_r;

    always_comb begin
        big   = (amt_i > W[W-1:0]);
        amt_s = big ? '0 : amt_i[SW-1:0];
        ext_l = {{W{1'b0}}, a_i} << amt_s;
        ext_r = {a_i, {W{1'b0}}} >> amt_s;
        if (big) begin
            res_o = '0;
            c_o   = 1'b0;
        end else if (right_i) begin
            res_o = ext_r[XW-1:W];
            c_o   = (amt_s != '0) && ext_r[W-1];
        end else begin
            res_o = ext_l[W-1:0];
            c_o   = (amt_s != '0) && ext_l[W];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [OPW-1:0] op_i,
    output logic [W-1:0]   res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            default: res_o = ~a_i;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [3:0]    opcode_i,
    input  logic [7:0]    opa_i,
    input  logic [7:0]    opb_i,
    output logic [7:0]    result_o,
    output logic [7:0]    flags_o
);
    logic [DW-1:0] as_res, md_res, sh_res, lg_res;
    logic          as_c, as_v, md_c, md_v, sh_c;
    unit_out_t     sel_d;
    alu_state_t    st_d, st_q;
    logic          fire_d;

    alu8_addsub #(.W(DW)) u_addsub (
        .a_i(opa_i), .b_i(opb_i), .sub_i(opcode_i == OP_SUB),
        .res_o(as_res), .c_o(as_c), .v_o(as_v)
    );

    alu8_muldiv #(.W(DW)) u_muldiv (
        .a_i(opa_i), .b_i(opb_i), .div_i(opcode_i == OP_DIV),
        .res_o(md_res), .c_o(md_c), .v_o(md_v)
    );

    alu8_shift #(.W(DW)) u_shift (
        .a_i(opa_i), .amt_i(opb_i), .right_i(opcode_i == OP_SHR),
        .res_o(sh_res), .c_o(sh_c)
    );

    alu8_logic #(.W(DW)) u_logic (
        .a_i(opa_i), .b_i(opb_i), .op_i(opcode_i), .res_o(lg_res)
    );

    always_comb begin
        fire_d = exec_i && is_alu_op(opcode_i);
        unique case (opcode_i)
            OP_ADD, OP_SUB: sel_d = '{res: as_res, c: as_c, v: as_v};
            OP_MUL, OP_DIV: sel_d = '{res: md_res, c: md_c, v: md_v};
            OP_SHL, OP_SHR: sel_d = '{res: sh_res, c: sh_c, v: 1'b0};
            default:        sel_d = '{res: lg_res, c: 1'b0, v: 1'b0};
        endcase

        st_d = st_q;
        if (fire_d) begin
            st_d.result       = sel_d.res;
            st_d.flags        = '0;
            st_d.flags[FLG_Z] = (sel_d.res == '0);
            st_d.flags[FLG_N] = sel_d.res[DW-1];
            st_d.flags[FLG_C] = sel_d.c;
            st_d.flags[FLG_V] = sel_d.v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign flags_o  = st_q.flags;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_i && is_alu_op(opcode_i)) |=> $stable(result_o) && $stable(flags_o)); // R9
    AST_ZN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_alu_op(opcode_i)) |=> (flags_o[0] == (result_o == 8'h00)) && (flags_o[1] == result_o[7])); // R8
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_alu_op(opcode_i)) |=> (flags_o[7:4] == 4'h0)); // R8
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i == OP_DIV && opb_i == 8'h00) |=> (result_o == 8'hFF) && flags_o[3] && !flags_o[2]); // R5
    AST_MUL_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i == OP_MUL) |=> !flags_o[3]); // R4
    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && opcode_i >= OP_NOT && opcode_i <= OP_OR) |=> (flags_o[3:2] == 2'b00)); // R7
    AST_SHIFT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (opcode_i == OP_SHL || opcode_i == OP_SHR) && opb_i >= 8'd8) |=> (result_o == 8'h00) && !flags_o[3]); // R6
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_i = 1'b0;
    logic [3:0] opcode_i = 4'h0;
    logic [7:0] opa_i = 8'h00;
    logic [7:0] opb_i = 8'h00;
    logic [7:0] result_o, flags_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] q_res[$];
    logic [7:0] q_flg[$];
    string      q_tag[$];
    logic [7:0] cur_res = 8'h00;
    logic [7:0] cur_flg = 8'h00;

    always #4 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .flags_o(flags_o)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // reference computed from the requirements: returns {flags, result}
    function automatic logic [15:0] model(input logic [3:0] op, input int a, input int b);
        int r = 0, c = 0, v = 0, s;
        case (op)
            4'b0100: begin s = a + b; r = s % 256; c = (s > 255);
                           s = sgn(a) + sgn(b); v = (s > 127 || s < -128); end
            4'b0101: begin r = (a - b + 256) % 256; c = (a < b);
                           s = sgn(a) - sgn(b); v = (s > 127 || s < -128); end
            4'b0110: begin s = a * b; r = s % 256; c = (s > 255); end
            4'b0111: begin if (b == 0) begin r = 255; v = 1; end else r = a / b; end
            4'b1000: begin if (b == 0) r = a;
                           else if (b <= 8) begin r = (a << b) % 256; c = (a >> (8 - b)) & 1; end end
            4'b1001: begin if (b == 0) r = a;
                           else if (b <= 8) begin r = a >> b; c = (a >> (b - 1)) & 1; end end
            4'b1010: r = 255 - a;
            4'b1011: r = a & b;
            4'b1100: r = a ^ b;
            4'b1101: r = a | b;
            default: r = 0;
        endcase
        return {4'h0, v[0], c[0], r[7], (r == 0), r[7:0]};
    endfunction

    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input string tag);
        logic [15:0] m;
        @(negedge clk);
        exec_i = 1'b1; opcode_i = op; opa_i = a; opb_i = b;
        if (op >= 4'b0100 && op <= 4'b1101) begin
            m = model(op, int'(a), int'(b));
            cur_res = m[7:0];
            cur_flg = m[15:8];
        end
        q_res.push_back(cur_res);
        q_flg.push_back(cur_flg);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        exec_i = 1'b0;
    endtask

    // monitor: an executed operation is visible after the next edge
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && exec_i) begin
                @(negedge clk);
                if (q_res.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R1 unexpected execution: got %02h/%02h expected none", result_o, flags_o);
                end else begin
                    logic [7:0] er, ef;
                    string t;
                    er = q_res.pop_front(); ef = q_flg.pop_front(); t = q_tag.pop_front();
                    n_tests++;
                    if (result_o !== er || flags_o !== ef) begin
                        n_fail++;
                        $display("FAIL %s: result/flags got %02h/%02h expected %02h/%02h", t, result_o, flags_o, er, ef);
                    end
                end
            end
        end
    end

    task automatic check_now(input string tag, input logic [7:0] er, input logic [7:0] ef);
        n_tests++;
        if (result_o !== er || flags_o !== ef) begin
            n_fail++;
            $display("FAIL %s: result/flags got %02h/%02h expected %02h/%02h", tag, result_o, flags_o, er, ef);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check_now("R10 reset", 8'h00, 8'h00);
        rst_n = 1'b1;

        // R2 add corners
        issue(4'b0100, 8'd3,   8'd5,   "R2 add small");    idle();
        issue(4'b0100, 8'h7F,  8'h01,  "R2 add signed ovf");
        issue(4'b0100, 8'hFF,  8'h01,  "R2 add carry zero");
        issue(4'b0100, 8'h80,  8'h80,  "R2 add neg ovf");   idle();
        // R3 subtract
        issue(4'b0101, 8'd3,   8'd5,   "R3 sub borrow");
        issue(4'b0101, 8'h80,  8'h01,  "R3 sub signed ovf");
        issue(4'b0101, 8'd9,   8'd9,   "R3 sub zero");      idle();
        // R4 multiply
        issue(4'b0110, 8'd3,   8'd5,   "R4 mul small");
        issue(4'b0110, 8'd16,  8'd16,  "R4 mul high carry");
        issue(4'b0110, 8'd20,  8'd13,  "R4 mul wrap");      idle();
        // R5 divide
        issue(4'b0111, 8'd200, 8'd7,   "R5 div trunc");
        issue(4'b0111, 8'd5,   8'd0,   "R5 div by zero");
        issue(4'b0111, 8'd3,   8'd9,   "R5 div zero quot"); idle();
        // R6 shifts
        issue(4'b1000, 8'hB5,  8'd0,   "R6 shl by 0");
        issue(4'b1000, 8'hB5,  8'd1,   "R6 shl by 1");
        issue(4'b1000, 8'hB5,  8'd3,   "R6 shl by 3");
        issue(4'b1000, 8'hB5,  8'd8,   "R6 shl by 8");
        issue(4'b1000, 8'hB5,  8'd9,   "R6 shl by 9");
        issue(4'b1001, 8'hB5,  8'd0,   "R6 shr by 0");
        issue(4'b1001, 8'hB5,  8'd1,   "R6 shr by 1");
        issue(4'b1001, 8'hB5,  8'd4,   "R6 shr by 4");
        issue(4'b1001, 8'hB5,  8'd8,   "R6 shr by 8");
        issue(4'b1001, 8'hB5,  8'd200, "R6 shr by 200");    idle();
        // R7 logic ops, complement ignores B
        issue(4'b1010, 8'h3C,  8'h00,  "R7 not b=00");
        issue(4'b1010, 8'h3C,  8'hFF,  "R7 not b=ff");
        issue(4'b1010, 8'hFF,  8'h5A,  "R7 not to zero");
        issue(4'b1011, 8'hF0,  8'h3C,  "R7 and");
        issue(4'b1100, 8'hF0,  8'h3C,  "R7 xor");
        issue(4'b1101, 8'h80,  8'h01,  "R7 or");
        issue(4'b1100, 8'h5A,  8'h5A,  "R8 xor zero flag"); idle();
        // R9: invalid opcodes with strobe, then idle with changed inputs
        issue(4'b0000, 8'hFF,  8'hFF,  "R9 opcode 0000");
        issue(4'b0011, 8'h01,  8'h02,  "R9 opcode 0011");
        issue(4'b1110, 8'h01,  8'h02,  "R9 opcode 1110");
        issue(4'b1111, 8'h00,  8'h00,  "R9 opcode 1111");   idle();
        @(negedge clk);
        opcode_i = 4'b0100; opa_i = 8'h11; opb_i = 8'h22;
        @(negedge clk);
        check_now("R9 idle hold", cur_res, cur_flg);
        // R1: back-to-back distinct operations
        issue(4'b0100, 8'd1,   8'd1,   "R1 b2b add");
        issue(4'b0110, 8'd7,   8'd6,   "R1 b2b mul");
        issue(4'b1001, 8'h80,  8'd7,   "R1 b2b shr");       idle();
        repeat (3) @(negedge clk);
        n_tests++;
        if (q_res.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending results: got %0d expected 0", q_res.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule